// File: doc/BRIEF.md
# Configurable Split 16x16 Multiplier

This block multiplies two 16-bit operands and builds every result out of 8-bit by 8-bit partial products. It presents three results at once: the product of the two high bytes, the product of the two low bytes, and the full 32-bit product. A compile-time flag for each operand selects unsigned or two's-complement interpretation. Only the high byte of a signed operand carries the sign, so the low-byte product is always unsigned.

Each operand may pass through an optional input register with a hold control. Optional stages can be placed after each 8x8 result and at two points of the 16x16 path: one after the partial products and one after their combination. Two synchronous reset inputs each clear their own group of registers. A clock enable gates every register. A low-power option leaves out the cross partial products and the 16x16 combination, which leaves only the two 8x8 results live. Accumulation and output selection are done outside this block.

Top module: `split_mult16`

## Requirements
- R1: `prod_o` equals the product of `a_i` and `b_i`, truncated to 32 bits. Each operand is read as two's complement when its signedness parameter is 1 and as unsigned when it is 0 (the default). For example, 0x8000 times 0x8000 with both signed gives 0x40000000.
- R2: `hi_prod_o` is the 16-bit product of `a_i[15:8]` and `b_i[15:8]`. Each of these bytes is signed exactly when its operand is signed. `lo_prod_o` is the unsigned 16-bit product of `a_i[7:0]` and `b_i[7:0]`.
- R3: When an operand's input register is present, a high hold input keeps the stored operand and a low hold input loads new data on the clock edge. When the register is absent, the hold input has no effect on any output.
- R4: A high `rst_hi` on an enabled edge clears the A input register and the high-byte product register. A high `rst_lo` clears the B input register, the low-byte product register, and both 16x16 stage registers. Reset takes priority over hold.
- R5: The latency of `hi_prod_o` is the A/B input-register count plus the high-byte stage count. The same rule applies to `lo_prod_o` with the low-byte stage. The latency of `prod_o` is the input-register count plus the two 16x16 stage counts. A disabled stage adds no cycle.
- R6: With the low-power option set, `prod_o` stays at zero while `hi_prod_o` and `lo_prod_o` keep to R2 and R5.
- R7: While `ce` is low, no register changes, and that includes a register whose reset input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| ce | input | 1 | Clock enable for every register |
| rst_hi | input | 1 | Synchronous clear of the A register and high-byte stage |
| rst_lo | input | 1 | Synchronous clear of the B register, low-byte stage and 16x16 stages |
| hold_a | input | 1 | 1 keeps the A input register, 0 loads it |
| hold_b | input | 1 | 1 keeps the B input register, 0 loads it |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| hi_prod_o | output | 16 | High-byte by high-byte product |
| lo_prod_o | output | 16 | Low-byte by low-byte product |
| prod_o | output | 32 | Full product |

## Verification
Two events can land on one register in the same cycle. First, a hold and a reset can both be high, and the reset must win. Second, a reset can be high while the clock enable is low, and the enable must block it. The bench drives random holds, resets and enables together across seventeen register and signedness configurations that share one stimulus stream. Every output of every configuration is compared each cycle against an arithmetic model of the operand and stage registers.

// File: rtl/smul_pkg.sv
package smul_pkg;
  parameter int unsigned SMUL_HALF = 8;
  localparam int unsigned SMUL_OP_W   = 2 * SMUL_HALF;
  localparam int unsigned SMUL_PP_W   = 2 * (SMUL_HALF + 1);
  localparam int unsigned SMUL_PROD_W = 2 * SMUL_OP_W;
  localparam int unsigned SMUL_ACC_W  = SMUL_PROD_W + 2;

  typedef logic [SMUL_HALF-1:0] half_t;
  typedef logic signed [SMUL_PP_W-1:0] pp_t;

  typedef struct packed {
    pp_t hh;
    pp_t hl;
    pp_t lh;
    pp_t ll;
  } pp_set_t;

  // byte product; xs/ys mark a byte whose top bit is a sign
  function automatic pp_t half_mul(half_t x, half_t y, logic xs, logic ys);
    pp_t xe;
    pp_t ye;
    xe = {{(SMUL_PP_W - SMUL_HALF){xs & x[SMUL_HALF-1]}}, x};
    ye = {{(SMUL_PP_W - SMUL_HALF){ys & y[SMUL_HALF-1]}}, y};
    return xe * ye;
  endfunction

  function automatic logic signed [SMUL_ACC_W-1:0] widen_pp(pp_t p);
    return {{(SMUL_ACC_W - SMUL_PP_W){p[SMUL_PP_W-1]}}, p};
  endfunction

  // weight the four byte products by their byte positions and sum
  function automatic logic [SMUL_PROD_W-1:0] merge_pp(pp_set_t s);
    logic signed [SMUL_ACC_W-1:0] acc;
    acc = (widen_pp(s.hh) <<< SMUL_OP_W)
        + ((widen_pp(s.hl) + widen_pp(s.lh)) <<< SMUL_HALF)
        + widen_pp(s.ll);
    return acc[SMUL_PROD_W-1:0];
  endfunction
endpackage

// File: rtl/smul_opreg.sv
module smul_opreg #(
  parameter int unsigned W  = 16,
  parameter bit          EN = 1'b0
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic         load_ev;
      logic         clear_ev;
      assign load_ev  = ce & ~rst & ~hold;
      assign clear_ev = ce & rst;

      always_ff @(posedge clk) begin
        if (clear_ev)     q_r <= '0;
        else if (load_ev) q_r <= d;
      end
      assign q = q_r;

      // R3: hold keeps the operand
      assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (ce && hold) |=> $stable(q));
      // R4: reset wins over hold
      assert_reset_wins_R4: assert property (@(posedge clk) disable iff (!ce)
        (rst && hold) |=> (q == '0));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/smul_pipe.sv
module smul_pipe #(
  parameter int unsigned W  = 16,
  parameter bit          EN = 1'b0
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (ce) begin
          if (rst) q_r <= '0;
          else     q_r <= d;
        end
      end
      assign q = q_r;

      // R7: a low enable freezes the stage even under reset
      assert_ce_freeze_R7: assert property (@(posedge clk) disable iff (ce)
        1'b1 |=> $stable(q));
      // R4: enabled reset clears the stage
      assert_stage_clear_R4: assert property (@(posedge clk) disable iff (!ce)
        rst |=> (q == '0));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/smul_ppmul.sv
module smul_ppmul
  import smul_pkg::*;
#(
  parameter bit A_S     = 1'b0,
  parameter bit B_S     = 1'b0,
  parameter bit FULL_EN = 1'b1
) (
  input  logic [SMUL_OP_W-1:0] a,
  input  logic [SMUL_OP_W-1:0] b,
  output pp_set_t              pp_o
);
  half_t a_hi, a_lo, b_hi, b_lo;
  assign a_hi = a[SMUL_OP_W-1:SMUL_HALF];
  assign a_lo = a[SMUL_HALF-1:0];
  assign b_hi = b[SMUL_OP_W-1:SMUL_HALF];
  assign b_lo = b[SMUL_HALF-1:0];

  assign pp_o.hh = half_mul(a_hi, b_hi, A_S, B_S);
  assign pp_o.ll = half_mul(a_lo, b_lo, 1'b0, 1'b0);

  generate
    if (FULL_EN) begin : g_cross
      assign pp_o.hl = half_mul(a_hi, b_lo, A_S, 1'b0);
      assign pp_o.lh = half_mul(a_lo, b_hi, 1'b0, B_S);
    end else begin : g_idle
      assign pp_o.hl = '0;
      assign pp_o.lh = '0;
    end
  endgenerate
endmodule

// File: rtl/split_mult16.sv
module split_mult16
  import smul_pkg::*;
#(
  parameter bit A_SIGNED  = 1'b0,
  parameter bit B_SIGNED  = 1'b0,
  parameter bit A_REG     = 1'b0,
  parameter bit B_REG     = 1'b0,
  parameter bit HI_REG    = 1'b0,
  parameter bit LO_REG    = 1'b0,
  parameter bit MID_REG   = 1'b0,
  parameter bit OUT_REG   = 1'b0,
  parameter bit LOW_POWER = 1'b0
) (
  input  logic        clk,
  input  logic        ce,
  input  logic        rst_hi,
  input  logic        rst_lo,
  input  logic        hold_a,
  input  logic        hold_b,
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  output logic [15:0] hi_prod_o,
  output logic [15:0] lo_prod_o,
  output logic [31:0] prod_o
);
  localparam int unsigned HALF_PROD_W = 2 * SMUL_HALF;
  localparam int unsigned SET_W       = $bits(pp_set_t);

  logic [SMUL_OP_W-1:0] a_q, b_q;
  pp_set_t              pp_now;
  logic [HALF_PROD_W-1:0] hi_now, lo_now;

  smul_opreg #(.W(SMUL_OP_W), .EN(A_REG)) u_areg (
    .clk(clk), .ce(ce), .rst(rst_hi), .hold(hold_a), .d(a_i), .q(a_q));
  smul_opreg #(.W(SMUL_OP_W), .EN(B_REG)) u_breg (
    .clk(clk), .ce(ce), .rst(rst_lo), .hold(hold_b), .d(b_i), .q(b_q));

  smul_ppmul #(.A_S(A_SIGNED), .B_S(B_SIGNED), .FULL_EN(!LOW_POWER)) u_pp (
    .a(a_q), .b(b_q), .pp_o(pp_now));

  assign hi_now = pp_now.hh[HALF_PROD_W-1:0];
  assign lo_now = pp_now.ll[HALF_PROD_W-1:0];

  smul_pipe #(.W(HALF_PROD_W), .EN(HI_REG)) u_hi (
    .clk(clk), .ce(ce), .rst(rst_hi), .d(hi_now), .q(hi_prod_o));
  smul_pipe #(.W(HALF_PROD_W), .EN(LO_REG)) u_lo (
    .clk(clk), .ce(ce), .rst(rst_lo), .d(lo_now), .q(lo_prod_o));

  generate
    if (!LOW_POWER) begin : g_full
      logic [SET_W-1:0]       mid_q;
      pp_set_t                pp_mid;
      logic [SMUL_PROD_W-1:0] full_now;

      smul_pipe #(.W(SET_W), .EN(MID_REG)) u_mid (
        .clk(clk), .ce(ce), .rst(rst_lo), .d(pp_now), .q(mid_q));
      assign pp_mid   = pp_set_t'(mid_q);
      assign full_now = merge_pp(pp_mid);

      smul_pipe #(.W(SMUL_PROD_W), .EN(OUT_REG)) u_out (
        .clk(clk), .ce(ce), .rst(rst_lo), .d(full_now), .q(prod_o));

      if (!A_REG && !B_REG && !MID_REG && !OUT_REG && !LO_REG) begin : g_chk
        // R1: low byte of the full product matches the low-byte product
        always_comb begin
          assert_lowbyte_match_R1: assert (prod_o[7:0] == lo_prod_o[7:0])
            else $error("low byte mismatch");
        end
      end
    end else begin : g_lp
      assign prod_o = '0;
    end
  endgenerate
endmodule

// File: tb/split_mult16_test.sv
module split_mult16_test;
  localparam int NCFG = 17;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic ce, rst_hi, rst_lo, hold_a, hold_b;
  logic [15:0] a, b;
  logic [15:0] hi_w [NCFG];
  logic [15:0] lo_w [NCFG];
  logic [31:0] pr_w [NCFG];
  int checks = 0;
  int errors = 0;

  function automatic bit c_in(int k); return (k == 16) ? 1'b1 : k[0]; endfunction
  function automatic bit c_pp(int k); return (k == 16) ? 1'b1 : k[1]; endfunction
  function automatic bit c_p1(int k); return (k == 16) ? 1'b1 : k[2]; endfunction
  function automatic bit c_p2(int k); return (k == 16) ? 1'b1 : k[3]; endfunction
  function automatic bit c_sa(int k); return (k == 16) ? 1'b1 : (k[0] ^ k[2]); endfunction
  function automatic bit c_sb(int k); return (k == 16) ? 1'b1 : (k[1] ^ k[3]); endfunction
  function automatic bit c_lp(int k); return (k == 16); endfunction

  genvar k;
  generate
    for (k = 0; k < NCFG; k++) begin : g
      split_mult16 #(
        .A_SIGNED(c_sa(k)), .B_SIGNED(c_sb(k)),
        .A_REG(c_in(k)), .B_REG(c_in(k)),
        .HI_REG(c_pp(k)), .LO_REG(c_pp(k)),
        .MID_REG(c_p1(k)), .OUT_REG(c_p2(k)),
        .LOW_POWER(c_lp(k))
      ) uut (
        .clk(clk), .ce(ce), .rst_hi(rst_hi), .rst_lo(rst_lo),
        .hold_a(hold_a), .hold_b(hold_b), .a_i(a), .b_i(b),
        .hi_prod_o(hi_w[k]), .lo_prod_o(lo_w[k]), .prod_o(pr_w[k]));
    end
  endgenerate

  // arithmetic references taken on whole operands
  function automatic logic [31:0] ref_full(logic [15:0] x, logic [15:0] y, bit sx, bit sy);
    logic signed [33:0] ex, ey, p;
    ex = {{18{sx & x[15]}}, x};
    ey = {{18{sy & y[15]}}, y};
    p = ex * ey;
    return p[31:0];
  endfunction
  function automatic logic [15:0] ref_hi(logic [15:0] x, logic [15:0] y, bit sx, bit sy);
    logic signed [17:0] ex, ey, p;
    ex = {{10{sx & x[15]}}, x[15:8]};
    ey = {{10{sy & y[15]}}, y[15:8]};
    p = ex * ey;
    return p[15:0];
  endfunction
  function automatic logic [15:0] ref_lo(logic [15:0] x, logic [15:0] y);
    return {8'h00, x[7:0]} * {8'h00, y[7:0]};
  endfunction

  logic [15:0] mA [NCFG];
  logic [15:0] mB [NCFG];
  logic [15:0] mUp [NCFG];
  logic [15:0] mLo [NCFG];
  logic [31:0] mP1 [NCFG];
  logic [31:0] mOut [NCFG];

  task automatic check(string tag, int kk, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cfg %0d %s got %h exp %h", tag, kk, what, got, exp);
    end
  endtask

  task automatic step(string tag, bit ce_v, bit rh, bit rl, bit ha, bit hb,
                      logic [15:0] av, logic [15:0] bv, bit chk);
    @(negedge clk);
    ce = ce_v; rst_hi = rh; rst_lo = rl; hold_a = ha; hold_b = hb; a = av; b = bv;
    #1;
    for (int i = 0; i < NCFG; i++) begin
      logic [15:0] opa, opb, hc, lc, he, le;
      logic [31:0] fc, s1, pe;
      opa = c_in(i) ? mA[i] : av;
      opb = c_in(i) ? mB[i] : bv;
      hc = ref_hi(opa, opb, c_sa(i), c_sb(i));
      lc = ref_lo(opa, opb);
      fc = c_lp(i) ? 32'h0 : ref_full(opa, opb, c_sa(i), c_sb(i));
      he = c_pp(i) ? mUp[i] : hc;
      le = c_pp(i) ? mLo[i] : lc;
      s1 = c_p1(i) ? mP1[i] : fc;
      pe = c_p2(i) ? mOut[i] : s1;
      if (chk) begin
        check(tag, i, "hi (R2)", {16'h0, hi_w[i]}, {16'h0, he});
        check(tag, i, "lo (R2)", {16'h0, lo_w[i]}, {16'h0, le});
        check(tag, i, c_lp(i) ? "prod (R6)" : "prod (R1)", pr_w[i], pe);
      end
      if (ce_v) begin
        mA[i]   = rh ? 16'h0 : (ha ? mA[i] : av);
        mB[i]   = rl ? 16'h0 : (hb ? mB[i] : bv);
        mUp[i]  = rh ? 16'h0 : hc;
        mLo[i]  = rl ? 16'h0 : lc;
        mP1[i]  = rl ? 32'h0 : fc;
        mOut[i] = rl ? 32'h0 : s1;
      end
    end
  endtask

  logic [15:0] corner [10] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF,
                               16'h7FFF, 16'h8000, 16'h8080, 16'hFF00, 16'hFFFF};

  initial begin
    for (int i = 0; i < NCFG; i++) begin
      mA[i] = '0; mB[i] = '0; mUp[i] = '0; mLo[i] = '0; mP1[i] = '0; mOut[i] = '0;
    end
    ce = 1'b1; rst_hi = 1'b1; rst_lo = 1'b1; hold_a = 1'b0; hold_b = 1'b0;
    a = 16'h0; b = 16'h0;
    // R4: reset state
    step("R4 reset", 1, 1, 1, 0, 0, 16'h1234, 16'h5678, 0);
    for (int i = 0; i < 3; i++) step("R4 reset", 1, 1, 1, 1, 1, 16'hA5C3, 16'h8001, 1);
    // R1 R2 R5: corner pairs including 0x8000 x 0x8000
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        step("R1 R2 R5 corner", 1, 0, 0, 0, 0, corner[i], corner[j], 1);
    // R5: random stream through every stage combination
    for (int i = 0; i < 600; i++)
      step("R5 random", 1, 0, 0, 0, 0, 16'($urandom), 16'($urandom), 1);
    // R3: hold on the operand registers
    for (int i = 0; i < 300; i++)
      step("R3 hold", 1, 0, 0, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1);
    // R4: resets colliding with holds
    for (int i = 0; i < 300; i++)
      step("R4 reset/hold", 1, ($urandom % 4) == 0, ($urandom % 4) == 0,
           1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1);
    // R7: enable low, sometimes with reset high
    for (int i = 0; i < 300; i++)
      step("R7 enable", 1'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0,
           1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule